// File: doc/BRIEF.md
# Latched-Level GPIO Controller

This block is a twelve-pin general-purpose I/O controller that sits on a plain 32-bit register bus. The bus has separate read and write strobes, a word address, and a write-data and a read-data word. Software sets the level each pin drives and whether the driver is on. It reads back the pin levels after they have been synchronised to the clock. It also stores a 32-bit pin-mux word, which the block presents unchanged on an output port.

Each pin has an interrupt latch. The latch captures a level condition whose polarity software chooses. Because the trigger is a level and the latch is re-armed on every clock, an acknowledge that arrives while the source is still active has no lasting effect: the bit sets again on the next clock. An enable mask selects which latched bits reach the single shared interrupt line, and that line is registered.

Top module: `gpio_latched_ctrl`

## Requirements
- R1: After reset, every register reads zero and `irq`, `pin_out` and `pin_oe` are low. This means all pins start masked.
- R2: A write to word 0 sets `pin_out`, and a write to word 1 sets `pin_oe`. Both take effect on the clock of the write. Bit n of each register belongs to pin n.
- R3: A read of word 2 returns the pin levels after a two-flop synchroniser. A change on `pin_in` is first visible in this register two clocks after it is applied.
- R4: Pins 0 to 7 take their polarity from word 4, and pins 8 to 11 from word 6. The bit for pin n is at position 4*(n mod 8). A value of 0 means active-high and a value of 1 means active-low.
- R5: Status (word 3) bit n sets on the clock after the synchronised level of pin n is at its active level. The bit then stays set after the source goes away.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If the source is still active, the bit sets again on the same clock, so a read that follows shows it set.
- R7: `irq` is the registered OR of status ANDed with enable (word 5). It follows that value one clock later.
- R8: An enable bit of 0 masks the pin from `irq`, but the pin's status bit still latches.
- R9: A write to word 7 stores all 32 bits. The value appears on `mux_sel` and reads back from word 7.
- R10: In the per-pin registers, bits that belong to no pin read as zero and ignore writes. Words 4 and 6 return only their polarity positions. Word addresses 8 and above read as zero. When `bus_rd` is low, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational while `bus_rd` is high |
| pin_in | input | 12 | Asynchronous pin levels |
| pin_out | output | 12 | Output data per pin |
| pin_oe | output | 12 | Output enable per pin |
| mux_sel | output | 32 | Stored pin-mux word |
| irq | output | 1 | Shared interrupt, registered |

## Verification
The assertions check four things on every cycle:
- `irq` follows the masked status one clock later.
- A fully masked enable keeps `irq` low.
- A latched bit survives unless it is acknowledged.
- An active synchronised level always leaves its status bit set on the next clock.

They also check that unused read bits and unmapped addresses return zero. Some behaviours only the bench scenarios can show: the two-clock input latency, the choice of polarity register and bit position for each pin, the acknowledge that re-latches at once while the source stays active, and the round trip of the mux word. The bench reaches these through a behavioural model and explicit expected reads.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Word-address map of the register file (byte offset = 4 * word).
    typedef enum logic [2:0] {
        SEL_OUT    = 3'd0,
        SEL_OE     = 3'd1,
        SEL_IN     = 3'd2,
        SEL_STAT   = 3'd3,
        SEL_POL_LO = 3'd4,
        SEL_EN     = 3'd5,
        SEL_POL_HI = 3'd6,
        SEL_MUX    = 3'd7
    } reg_sel_e;

    // Number of pins whose polarity bits share one type register.
    localparam int POL_PER_REG = 8;
    // Stride between polarity bits inside a type register.
    localparam int POL_STRIDE  = 4;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [STAGES-1:0][WIDTH-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_latch.sv
module gpio_irq_latch #(
    parameter int NPINS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] sync_lvl,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] ack,
    output logic [NPINS-1:0] status,
    output logic             irq
);

    typedef struct packed {
        logic [NPINS-1:0] stat;
        logic             irq;
    } latch_t;

    latch_t lat_d, lat_q;
    logic [NPINS-1:0] hit;

    always_comb begin
        lat_d = lat_q;
        // polarity 1 inverts the level: low becomes the active state
        hit = sync_lvl ^ pol;
        // set has priority over acknowledge so an active source re-latches
        lat_d.stat = (lat_q.stat & ~ack) | hit;
        lat_d.irq  = |(lat_q.stat & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign status = lat_q.stat;
    assign irq    = lat_q.irq;

endmodule

// File: rtl/gpio_latched_ctrl.sv
module gpio_latched_ctrl #(
    parameter int NPINS       = 12,
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [DATA_W-1:0] mux_sel,
    output logic              irq
);
    import gpio_pkg::*;

    localparam int PPR = POL_PER_REG;
    localparam int STR = POL_STRIDE;

    typedef struct packed {
        logic [NPINS-1:0]  out;
        logic [NPINS-1:0]  oe;
        logic [NPINS-1:0]  en;
        logic [NPINS-1:0]  pol;
        logic [DATA_W-1:0] mux;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic [NPINS-1:0] ack;
    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] irq_stat;
    logic [NPINS-1:0] pol_vec;
    logic [NPINS-1:0] en_vec;
    logic             mapped;
    reg_sel_e         sel;

    assign mapped = (bus_addr[ADDR_W-1:3] == '0);
    assign sel    = reg_sel_e'(bus_addr[2:0]);

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (sync_lvl)
    );

    gpio_irq_latch #(.NPINS(NPINS)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_lvl (sync_lvl),
        .pol      (regs_q.pol),
        .en       (regs_q.en),
        .ack      (ack),
        .status   (irq_stat),
        .irq      (irq)
    );

    // next-state of the software-visible registers
    always_comb begin
        regs_d = regs_q;
        ack    = '0;
        if (bus_wr && mapped) begin
            case (sel)
                SEL_OUT:  regs_d.out = bus_wdata[NPINS-1:0];
                SEL_OE:   regs_d.oe  = bus_wdata[NPINS-1:0];
                SEL_EN:   regs_d.en  = bus_wdata[NPINS-1:0];
                SEL_STAT: ack        = bus_wdata[NPINS-1:0];
                SEL_MUX:  regs_d.mux = bus_wdata;
                SEL_POL_LO: begin
                    for (int n = 0; n < NPINS; n++) begin
                        if (n < PPR) regs_d.pol[n] = bus_wdata[STR*(n%PPR)];
                    end
                end
                SEL_POL_HI: begin
                    for (int n = 0; n < NPINS; n++) begin
                        if (n >= PPR) regs_d.pol[n] = bus_wdata[STR*(n%PPR)];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_rd && mapped) begin
            case (sel)
                SEL_OUT:  bus_rdata[NPINS-1:0] = regs_q.out;
                SEL_OE:   bus_rdata[NPINS-1:0] = regs_q.oe;
                SEL_IN:   bus_rdata[NPINS-1:0] = sync_lvl;
                SEL_STAT: bus_rdata[NPINS-1:0] = irq_stat;
                SEL_EN:   bus_rdata[NPINS-1:0] = regs_q.en;
                SEL_MUX:  bus_rdata            = regs_q.mux;
                SEL_POL_LO: begin
                    for (int n = 0; n < NPINS; n++) begin
                        if (n < PPR) bus_rdata[STR*(n%PPR)] = regs_q.pol[n];
                    end
                end
                SEL_POL_HI: begin
                    for (int n = 0; n < NPINS; n++) begin
                        if (n >= PPR) bus_rdata[STR*(n%PPR)] = regs_q.pol[n];
                    end
                end
                default: ;
            endcase
        end
    end

    assign pin_out = regs_q.out;
    assign pin_oe  = regs_q.oe;
    assign mux_sel = regs_q.mux;
    assign pol_vec = regs_q.pol;
    assign en_vec  = regs_q.en;

endmodule

// File: rtl/gpio_latched_ctrl_chk.sv
module gpio_latched_ctrl_chk #(
    parameter int NPINS  = 12,
    parameter int ADDR_W = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  wdata_lo,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [NPINS-1:0]  lvl,
    input logic [NPINS-1:0]  pol,
    input logic [NPINS-1:0]  stat,
    input logic [NPINS-1:0]  en,
    input logic              irq
);

    logic [NPINS-1:0] ack_c, keep_c, act_c;
    logic             pin_word;

    always_comb begin
        ack_c  = (bus_wr && bus_addr == ADDR_W'(3)) ? wdata_lo : '0;
        keep_c = stat & ~ack_c;
        act_c  = lvl ^ pol;
        pin_word = (bus_addr == ADDR_W'(0)) || (bus_addr == ADDR_W'(1)) ||
                   (bus_addr == ADDR_W'(2)) || (bus_addr == ADDR_W'(3)) ||
                   (bus_addr == ADDR_W'(5));
    end

    // R7: shared line is the masked status of the previous clock
    p_irq_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == $past(|(stat & en))));

    // R8: nothing enabled means the line stays low next clock
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> !irq);

    // R5: a latched bit that is not acknowledged stays set
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(keep_c)) == $past(keep_c)));

    // R6: an active source leaves its bit set, acknowledge or not
    p_relatch_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & $past(act_c)) == $past(act_c)));

    // R10: per-pin words carry nothing above the pin count
    p_hi_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && pin_word) |-> ((bus_rdata >> NPINS) == '0));

    // R10: unmapped words and idle reads return zero
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd || bus_addr[ADDR_W-1:3] != '0) |-> (bus_rdata == '0));

endmodule

bind gpio_latched_ctrl gpio_latched_ctrl_chk #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .wdata_lo  (bus_wdata[NPINS-1:0]),
    .bus_rdata (bus_rdata),
    .lvl       (sync_lvl),
    .pol       (pol_vec),
    .stat      (irq_stat),
    .en        (en_vec),
    .irq       (irq)
);

// File: tb/gpio_latched_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_latched_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] pin_in = '0;
    logic [11:0] pin_out, pin_oe;
    logic [31:0] mux_sel;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    gpio_latched_ctrl u_gpio_latched_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .mux_sel(mux_sel), .irq(irq)
    );

    // behavioural reference model
    logic [11:0] m_out = '0, m_oe = '0, m_en = '0, m_stat = '0, m_pol = '0;
    logic [31:0] m_mux = '0;
    logic        m_irq = 1'b0;
    logic [11:0] pq[$] = '{12'h0, 12'h0};

    always @(posedge clk) begin
        logic [11:0] a, k;
        if (!rst_n) begin
            m_out = '0; m_oe = '0; m_en = '0; m_stat = '0; m_pol = '0;
            m_mux = '0; m_irq = 1'b0;
            pq = '{12'h0, 12'h0};
        end else begin
            a = pq[0] ^ m_pol;
            k = (bus_wr && bus_addr == 4'd3) ? bus_wdata[11:0] : 12'h0;
            m_irq  = |(m_stat & m_en);
            m_stat = (m_stat & ~k) | a;
            if (bus_wr) begin
                case (bus_addr)
                    4'd0: m_out = bus_wdata[11:0];
                    4'd1: m_oe  = bus_wdata[11:0];
                    4'd5: m_en  = bus_wdata[11:0];
                    4'd7: m_mux = bus_wdata;
                    4'd4: for (int n = 0; n < 8; n++) m_pol[n] = bus_wdata[4*n];
                    4'd6: for (int n = 8; n < 12; n++) m_pol[n] = bus_wdata[4*(n-8)];
                    default: ;
                endcase
            end
            void'(pq.pop_front());
            pq.push_back(pin_in);
        end
    end

    function automatic logic [31:0] model_read(input logic [3:0] a);
        logic [31:0] v = '0;
        case (a)
            4'd0: v[11:0] = m_out;
            4'd1: v[11:0] = m_oe;
            4'd2: v[11:0] = pq[0];
            4'd3: v[11:0] = m_stat;
            4'd5: v[11:0] = m_en;
            4'd7: v = m_mux;
            4'd4: for (int n = 0; n < 8; n++) v[4*n] = m_pol[n];
            4'd6: for (int n = 8; n < 12; n++) v[4*(n-8)] = m_pol[n];
            default: v = '0;
        endcase
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the model, away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !done) begin
            chk("R2 pin_out model", {20'h0, pin_out}, {20'h0, m_out});
            chk("R2 pin_oe model", {20'h0, pin_oe}, {20'h0, m_oe});
            chk("R7 irq model", {31'h0, irq}, {31'h0, m_irq});
            chk("R9 mux_sel model", mux_sel, m_mux);
        end
    end

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #0.5;
        chk(tag, bus_rdata, exp);
        chk({tag, " model"}, bus_rdata, model_read(a));
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4 * 100000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1: everything zero after reset
        for (int a = 0; a < 9; a++) rd(4'(a), 32'h0, "R1 reset read");
        chk("R1 irq low", {31'h0, irq}, 32'h0);
        chk("R1 pin_out low", {20'h0, pin_out}, 32'h0);
        // idle read returns zero
        #0.5 chk("R10 idle read", bus_rdata, 32'h0);

        // R2 and R10: drive registers, upper bits ignored
        wr(4'd0, 32'hFFFF_FABC);
        chk("R2 pin_out", {20'h0, pin_out}, 32'h0000_0ABC);
        wr(4'd1, 32'h0000_00F0);
        chk("R2 pin_oe", {20'h0, pin_oe}, 32'h0000_00F0);
        rd(4'd0, 32'h0000_0ABC, "R10 out upper bits");

        // R3: two-clock input latency
        @(negedge clk); pin_in = 12'h005;
        rd(4'd2, 32'h0, "R3 input after one clock");
        rd(4'd2, 32'h5, "R3 input after two clocks");
        rd(4'd3, 32'h5, "R5 status sets");

        // R5: latched after source leaves
        @(negedge clk); pin_in = 12'h000;
        idle(4);
        rd(4'd3, 32'h5, "R5 status holds");
        // R6: write-one clears, write-zero keeps
        wr(4'd3, 32'h1);
        rd(4'd3, 32'h4, "R6 partial ack");

        // R7: enable and shared line
        wr(4'd5, 32'h4);
        idle(1);
        chk("R7 irq asserted", {31'h0, irq}, 32'h1);
        wr(4'd3, 32'h4);
        idle(1);
        chk("R7 irq dropped", {31'h0, irq}, 32'h0);

        // R6: acknowledge while active re-latches
        @(negedge clk); pin_in = 12'h800;
        idle(4);
        wr(4'd3, 32'h800);
        rd(4'd3, 32'h800, "R6 relatch");

        // R8: masking
        wr(4'd5, 32'h800);
        idle(1);
        chk("R8 unmasked irq", {31'h0, irq}, 32'h1);
        wr(4'd5, 32'h0);
        idle(1);
        chk("R8 masked irq", {31'h0, irq}, 32'h0);
        rd(4'd3, 32'h800, "R8 status still latched");

        // R4: polarity registers and positions
        wr(4'd6, 32'h0000_1000);
        wr(4'd4, 32'h0000_0010);
        idle(1);
        wr(4'd3, 32'hFFF);
        rd(4'd3, 32'h002, "R4 active-low pins");
        rd(4'd4, 32'h0000_0010, "R4 type low readback");
        rd(4'd6, 32'h0000_1000, "R4 type high readback");

        // R9: mux word
        wr(4'd7, 32'hDEAD_BEEF);
        chk("R9 mux_sel", mux_sel, 32'hDEAD_BEEF);
        rd(4'd7, 32'hDEAD_BEEF, "R9 mux readback");

        // R10: unused bits and unmapped words
        wr(4'd4, 32'hFFFF_FFFF);
        rd(4'd4, 32'h1111_1111, "R10 type low stride bits");
        wr(4'd6, 32'hFFFF_FFFF);
        rd(4'd6, 32'h0000_1111, "R10 type high stride bits");
        wr(4'd1, 32'hFFFF_FFFF);
        rd(4'd1, 32'h0000_0FFF, "R10 oe upper bits");
        wr(4'd9, 32'hFFFF_FFFF);
        rd(4'd9, 32'h0, "R10 unmapped read");
        rd(4'd15, 32'h0, "R10 unmapped top read");

        idle(2);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule